// File: doc/BRIEF.md
# Early-Termination Iterative Multiplier

This block multiplies two 32-bit operands over several clock cycles. It adds an optional accumulator to the product. One start pulse loads both operands and the accumulator. After that, each cycle takes the next 12 bits of the second operand, starting from the least significant bits, and adds that partial product into a running 64-bit sum. The block stops as soon as the bits it has not yet consumed are a pure sign or zero extension. Small multipliers therefore finish sooner than large ones.

Three opcode bits select the operation. The first chooses signed or unsigned operands. The second chooses a 32-bit or a 64-bit result. The third enables the accumulate. A 64-bit result takes one extra cycle to settle the upper word. The caller raises `start` while `busy` is low. It then waits for the one-cycle `done` strobe, and the result is valid in that cycle. The result holds until the next operation completes.

Top module: `mul_early_term`

## Requirements
- R1: In the cycle after reset, busy and done are low and result is zero.
- R2: An unsigned operation with a 32-bit result (op_long=0) returns (a*b + acc) mod 2^32 in result[31:0], and result[63:32] is zero.
- R3: A signed operation with a 64-bit result returns the exact two's-complement product plus acc_in, modulo 2^64.
- R4: An unsigned operation with a 64-bit result returns (a*b + acc) mod 2^64, where a and b are read as values from 0 to 2^32-1.
- R5: With op_acc=1, a 32-bit operation adds acc_in[31:0] and a 64-bit operation adds all 64 bits of acc_in. With op_acc=0, acc_in has no effect on the result.
- R6: The iteration count k is 1 for an unsigned b below 2^12, 2 for b below 2^24, and 3 otherwise.
- R7: For a signed b, k is 1 when b lies in [-4096, 4095], 2 when b lies in [-2^24, 2^24-1], and 3 otherwise.
- R8: If start is high in cycle c, done is high in cycle c+1+k for a 32-bit result and in cycle c+2+k for a 64-bit result. This gives 2 to 4 cycles and 3 to 5 cycles.
- R9: done is a one-cycle pulse. busy is high from the cycle after start until the cycle before done, and it is low in the done cycle.
- R10: A start raised while busy is high is ignored. The running operation's result and timing are unchanged.
- R11: result keeps its value in every cycle in which done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a new operation (taken when busy is low) |
| op_signed | input | 1 | 1: operands are two's complement |
| op_long | input | 1 | 1: 64-bit result, 0: 32-bit result |
| op_acc | input | 1 | 1: add acc_in to the product |
| a | input | 32 | Multiplicand |
| b | input | 32 | Multiplier, consumed 12 bits per cycle |
| acc_in | input | 64 | Accumulator addend (low half only for 32-bit results) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Product (plus accumulator), held until the next done |

## Verification
A wrong termination decision shows up as a done strobe one or more cycles away from the slot predicted from the magnitude of b. It appears in the first operation whose b sits on a 12-bit or 24-bit boundary. A wrong partial-product step or a missing sign correction does not change the timing. It shows only as a wrong result value in the done cycle of an operation with a negative or multi-chunk b. Errors in the handshake are visible every cycle, because the bench compares busy and done against its model on every clock. This includes a start that is accepted while busy, or a stuck upper word.

// File: rtl/mul_et_pkg.sv
package mul_et_pkg;

    localparam int OPW    = 32;
    localparam int ACCW   = 2 * OPW;
    localparam int CHUNK  = 12;
    localparam int MAXIT  = (OPW + CHUNK - 1) / CHUNK;
    localparam int ITW    = $clog2(MAXIT + 1);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ITER = 2'd1,
        ST_FIN  = 2'd2
    } mul_state_e;

    typedef struct packed {
        logic is_signed;
        logic is_long;
        logic use_acc;
    } mul_op_t;

    function automatic logic [ACCW-1:0] widen(input logic [OPW-1:0] v, input logic sgn);
        widen = sgn ? {{(ACCW-OPW){v[OPW-1]}}, v} : {{(ACCW-OPW){1'b0}}, v};
    endfunction

endpackage

// File: rtl/mul_et_ctrl.sv
module mul_et_ctrl
    import mul_et_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic op_long,
    input  logic last,
    output logic load,
    output logic step,
    output logic fin_short,
    output logic fin_long,
    output logic busy,
    output logic done
);

    mul_state_e     state_q;
    logic           long_q;
    logic [ITW-1:0] cnt_q;

    assign load      = (state_q == ST_IDLE) && start;
    assign step      = (state_q == ST_ITER);
    assign fin_short = step && last && !long_q;
    assign fin_long  = (state_q == ST_FIN);
    assign busy      = (state_q != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            long_q  <= 1'b0;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= fin_short || fin_long;
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_ITER;
                    long_q  <= op_long;
                    cnt_q   <= '0;
                end
                ST_ITER: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last) state_q <= long_q ? ST_FIN : ST_IDLE;
                end
                ST_FIN:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R6/R7: no operation needs more than MAXIT iterations
    a_r7_iter_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ITER) |-> (cnt_q < ITW'(MAXIT)));

    // R9: completion strobe lasts one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: accepted start raises busy next cycle
    a_r9_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R9: busy is low while done is shown
    a_r9_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

endmodule

// File: rtl/mul_et_datapath.sv
module mul_et_datapath
    import mul_et_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  mul_op_t         op,
    input  logic [OPW-1:0]  a,
    input  logic [OPW-1:0]  b,
    input  logic [ACCW-1:0] acc_in,
    output logic            last,
    output logic [ACCW-1:0] sum_q,
    output logic [ACCW-1:0] sum_nx
);

    logic [ACCW-1:0]       mcand_q;
    logic signed [OPW:0]   rem_q;
    logic signed [OPW:0]   rest;
    logic [CHUNK-1:0]      digit;
    logic                  rest_neg;
    logic [ACCW-1:0]       partial;
    logic [ACCW-1:0]       fixup;
    logic [ACCW-1:0]       acc_init;

    assign digit    = rem_q[CHUNK-1:0];
    assign rest     = rem_q >>> CHUNK;
    assign rest_neg = &rest;
    assign last     = (rest == '0) || rest_neg;
    assign partial  = mcand_q * ACCW'(digit);
    assign fixup    = rest_neg ? (mcand_q << CHUNK) : '0;
    assign sum_nx   = sum_q + partial - fixup;

    always_comb begin
        acc_init = '0;
        if (op.use_acc)
            acc_init = op.is_long ? acc_in : {{(ACCW-OPW){1'b0}}, acc_in[OPW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
            rem_q   <= '0;
            sum_q   <= '0;
        end else if (load) begin
            mcand_q <= widen(a, op.is_signed);
            rem_q   <= op.is_signed ? {b[OPW-1], b} : {1'b0, b};
            sum_q   <= acc_init;
        end else if (step) begin
            mcand_q <= mcand_q << CHUNK;
            rem_q   <= rest;
            sum_q   <= sum_nx;
        end
    end

    // R6/R7: a step that does not finish leaves a non-trivial remainder
    a_r6_rem_shrinks: assert property (@(posedge clk) disable iff (rst)
        (step && !last) |=> (rem_q != '0) && !(&rem_q));

endmodule

// File: rtl/mul_early_term.sv
module mul_early_term
    import mul_et_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_signed,
    input  logic        op_long,
    input  logic        op_acc,
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic [63:0] acc_in,
    output logic        busy,
    output logic        done,
    output logic [63:0] result
);

    mul_op_t         op;
    logic            load, step, fin_short, fin_long, last;
    logic [ACCW-1:0] sum_q, sum_nx;

    assign op = '{is_signed: op_signed, is_long: op_long, use_acc: op_acc};

    mul_et_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .op_long   (op_long),
        .last      (last),
        .load      (load),
        .step      (step),
        .fin_short (fin_short),
        .fin_long  (fin_long),
        .busy      (busy),
        .done      (done)
    );

    mul_et_datapath u_dp (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .op     (op),
        .a      (a),
        .b      (b),
        .acc_in (acc_in),
        .last   (last),
        .sum_q  (sum_q),
        .sum_nx (sum_nx)
    );

    always_ff @(posedge clk) begin
        if (rst)
            result <= '0;
        else if (fin_short)
            result <= {{(ACCW-OPW){1'b0}}, sum_nx[OPW-1:0]};
        else if (fin_long)
            result <= sum_q;
    end

    // R11: result moves only when done is shown
    a_r11_result_hold: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    // R2: a short result finishes straight from the iteration state
    a_r2_short_upper_zero: assert property (@(posedge clk) disable iff (rst)
        fin_short |=> (result[63:32] == '0) && done);

endmodule

// File: tb/tb_mul_early_term.sv
module tb_mul_early_term;

    logic        clk = 1'b0;
    logic        rst;
    logic        start, op_signed, op_long, op_acc;
    logic [31:0] a, b;
    logic [63:0] acc_in;
    logic        busy, done;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mul_early_term dut (
        .clk(clk), .rst(rst), .start(start), .op_signed(op_signed),
        .op_long(op_long), .op_acc(op_acc), .a(a), .b(b), .acc_in(acc_in),
        .busy(busy), .done(done), .result(result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int iters(input logic [31:0] bv, input logic sgn);
        longint v = sgn ? longint'($signed(bv)) : longint'({32'b0, bv});
        for (int k = 1; k <= 3; k++) begin
            longint r = v >>> (12 * k);
            if (r == 0 || r == -1) return k;
        end
        return 3;
    endfunction

    function automatic logic [63:0] model(input logic sgn, input logic lng, input logic ac,
                                          input logic [31:0] av, input logic [31:0] bv,
                                          input logic [63:0] accv);
        longint x = sgn ? longint'($signed(av)) : longint'({32'b0, av});
        longint y = sgn ? longint'($signed(bv)) : longint'({32'b0, bv});
        logic [63:0] s = 64'(x * y);
        if (ac) s = s + (lng ? accv : {32'b0, accv[31:0]});
        return lng ? s : {32'b0, s[31:0]};
    endfunction

    // Launch one operation and compare busy/done every clock; optionally
    // poke a second start while busy (R10).
    task automatic run(input string req, input logic sgn, input logic lng, input logic ac,
                       input logic [31:0] av, input logic [31:0] bv, input logic [63:0] accv,
                       input bit poke);
        int lat = 1 + iters(bv, sgn) + (lng ? 1 : 0);
        logic [63:0] exp = model(sgn, lng, ac, av, bv, accv);
        op_signed = sgn; op_long = lng; op_acc = ac;
        a = av; b = bv; acc_in = accv; start = 1'b1;
        for (int i = 1; i <= lat; i++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && i == 1) begin
                start = 1'b1; a = ~av; b = 32'h0000_0003; acc_in = ~accv;
                op_long = ~lng;
            end
            check({req, " R9 busy"}, 64'(busy), 64'(i < lat));
            check({req, " R8 done timing"}, 64'(done), 64'(i == lat));
            if (i == lat) check({req, " result"}, result, exp);
        end
        start = 1'b0;
        @(negedge clk);
        check({req, " R9 done pulse"}, 64'(done), 64'd0);
        check({req, " R11 hold"}, result, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; start = 0; op_signed = 0; op_long = 0; op_acc = 0;
        a = '0; b = '0; acc_in = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy", 64'(busy), 64'd0);
        check("R1 done", 64'(done), 64'd0);
        check("R1 result", result, 64'd0);

        run("R2 small",         0, 0, 0, 32'd5,        32'd7,        64'd0, 0);
        run("R2 R6 b=0xfff",    0, 0, 0, 32'h1234_5678, 32'h0000_0fff, 64'd0, 0);
        run("R2 R6 b=0x1000",   0, 0, 0, 32'h1234_5678, 32'h0000_1000, 64'd0, 0);
        run("R2 R6 b=0xffffff", 0, 0, 0, 32'hdead_beef, 32'h00ff_ffff, 64'd0, 0);
        run("R2 R6 b=2^24",     0, 0, 0, 32'hdead_beef, 32'h0100_0000, 64'd0, 0);
        run("R4 R6 max",        0, 1, 0, 32'hffff_ffff, 32'hffff_ffff, 64'd0, 0);
        run("R4 R8 long short-b", 0, 1, 0, 32'h8000_0001, 32'h0000_0abc, 64'd0, 0);
        run("R3 R7 b=-1",       1, 1, 0, 32'h7654_3210, 32'hffff_ffff, 64'd0, 0);
        run("R3 R7 b=-4096",    1, 1, 0, 32'hfedc_ba98, 32'hffff_f000, 64'd0, 0);
        run("R3 R7 b=-4097",    1, 1, 0, 32'hfedc_ba98, 32'hffff_efff, 64'd0, 0);
        run("R3 R7 b=4095",     1, 1, 0, 32'h8000_0000, 32'h0000_0fff, 64'd0, 0);
        run("R3 R7 min*min",    1, 1, 0, 32'h8000_0000, 32'h8000_0000, 64'd0, 0);
        run("R3 R7 b=-2^24",    1, 1, 0, 32'h0012_3456, 32'hff00_0000, 64'd0, 0);
        run("R3 R7 b=-2^24-1",  1, 1, 0, 32'h0012_3456, 32'hfeff_ffff, 64'd0, 0);
        run("R2 R7 signed short", 1, 0, 0, 32'hffff_fffd, 32'h0000_0007, 64'd0, 0);
        run("R5 acc short",     0, 0, 1, 32'd1000,     32'd3000,     64'hffff_ffff_0000_0010, 0);
        run("R5 acc long",      1, 1, 1, 32'hffff_fff0, 32'h0001_0000, 64'h0123_4567_89ab_cdef, 0);
        run("R5 acc off",       0, 1, 0, 32'd12,       32'd12,       64'hffff_ffff_ffff_ffff, 0);
        run("R10 start busy",   0, 1, 1, 32'h0bad_f00d, 32'h0abc_def0, 64'h55, 1);
        run("R10 after poke",   1, 0, 1, 32'h0000_0002, 32'h0000_0002, 64'd3, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule